// File: doc/BRIEF.md
# Two-Wire Slave for Tuner Control and Status

This block is a serial two-wire (I2C) slave that lets a bus master program a small set of control bytes and read back an eight-bit status byte. A fast system clock oversamples SCL and SDA through synchronizers. START and STOP conditions are found by edge detection on the sampled lines. The slave responds to one of four 7-bit addresses. A 2-bit strap input picks which one, so several of these devices can share a bus.

In write mode, received bytes fill a register file starting at index 0 after each START. Control register 0 carries the power-down bit and the two port-enable bits. In read mode, the slave sends status bytes for as long as the master acknowledges them. The most significant status bit is the lock flag, and the same lock state also appears on a dedicated output. When the master does not acknowledge a status byte, the slave stops by itself and stays silent until the next START. The slave never drives SDA high: `sda_oe_o` high means the pad pulls SDA low.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 0x60 plus `addr_sel_i` (00→0x60, 01→0x61, 10→0x62, 11→0x63). Any other address gets no acknowledge, and the slave ignores all bytes until the next START.
- R2: In write mode (address LSB 0), every data byte is acknowledged. Data bytes are stored in order into registers 0, 1, 2, … of `ctrl_regs_o`, where register k occupies bits [8k+7:8k]. The index restarts at 0 after every START.
- R3: Data bytes that arrive after the last register (index NREG-1) are still acknowledged, but they change no register.
- R4: In read mode (address LSB 1), the slave shifts out status bytes MSB first. Each byte is {lock flag, `status_aux_i[6:0]`}. Bytes continue while the master acknowledges each one.
- R5: If the master leaves SDA high in a status acknowledge slot, the slave ends the read on its own. It releases SDA and drives nothing until a new START.
- R6: Each status byte is captured when its transfer begins. Changes on `status_aux_i` during that byte do not alter the bits sent.
- R7: `pwrdn_o` is high when `sleep_i` is high or register 0 bit 0 (power-down) is 1. It is low only when both are 0.
- R8: `port_pull_o[0]` follows register 0 bit 1 and `port_pull_o[1]` follows register 0 bit 2. A value of 1 pulls the open-drain port low. Both bits reset to 0, which leaves the ports released.
- R9: `lock_o` follows `lock_i` one clock later. The status lock flag (bit 7) carries the same value.
- R10: The slave changes its SDA drive only while SCL is low. A START or STOP that arrives in the middle of a byte discards the partial byte.
- R11: After reset, SDA is released and all control registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| addr_sel_i | input | 2 | Selects one of four slave addresses |
| sleep_i | input | 1 | External power-down request |
| lock_i | input | 1 | Lock detector state |
| status_aux_i | input | 7 | Lower seven status bits |
| ctrl_regs_o | output | NREG*8 | Control register file, register k at [8k+7:8k] |
| pwrdn_o | output | 1 | Combined power-down |
| port_pull_o | output | 2 | Open-drain port enables, 1 = pull low |
| lock_o | output | 1 | Lock indicator |

## Verification
The slave's SDA response appears three clocks after an SCL edge: two synchronizer stages plus the engine register. The bench therefore samples the line half an SCL-high phase after the rising edge, which is long after that delay. Register contents are checked only once a transaction has ended with STOP. `pwrdn_o` and `port_pull_o` are combinational from the registers and are compared one clock after a register write or a change of `sleep_i`. `lock_o` is compared one clock after `lock_i` changes.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } bus_st_e;

    localparam logic [6:0] BASE_ADDR = 7'h60;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
    import i2c_ctrl_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int IDX_W = $clog2(NREG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic [1:0]       addr_sel,
    input  logic [7:0]       status,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG);

    typedef struct packed {
        bus_st_e          st;
        logic             scl_p;
        logic             sda_p;
        logic [3:0]       cnt;
        logic [7:0]       sr;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] widx;
        logic             rw;
        logic             ack;
        logic             oe;
        logic             we;
    } eng_t;

    eng_t q_q, n_d;
    logic rise, fall, start_c, stop_c;

    assign rise    = scl_s & ~q_q.scl_p;
    assign fall    = ~scl_s & q_q.scl_p;
    assign start_c = scl_s & q_q.scl_p & q_q.sda_p & ~sda_s;
    assign stop_c  = scl_s & q_q.scl_p & ~q_q.sda_p & sda_s;

    always_comb begin
        n_d       = q_q;
        n_d.scl_p = scl_s;
        n_d.sda_p = sda_s;
        n_d.we    = 1'b0;
        if (start_c) begin
            n_d.st  = ST_ADDR;
            n_d.cnt = '0;
            n_d.idx = '0;
            n_d.oe  = 1'b0;
        end else if (stop_c) begin
            n_d.st = ST_IDLE;
            n_d.oe = 1'b0;
        end else begin
            unique case (q_q.st)
                ST_ADDR: begin
                    if (rise) begin
                        n_d.sr  = {q_q.sr[6:0], sda_s};
                        n_d.cnt = q_q.cnt + 4'd1;
                    end else if (fall && q_q.cnt == 4'd8) begin
                        if (q_q.sr[7:1] == (BASE_ADDR | {5'd0, addr_sel})) begin
                            n_d.st = ST_ADDR_ACK;
                            n_d.rw = q_q.sr[0];
                            n_d.oe = 1'b1;
                        end else begin
                            n_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall) begin
                        n_d.cnt = '0;
                        if (q_q.rw) begin
                            n_d.st = ST_RD;
                            n_d.sr = status;
                            n_d.oe = ~status[7];
                        end else begin
                            n_d.st = ST_WR;
                            n_d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (rise) begin
                        n_d.sr  = {q_q.sr[6:0], sda_s};
                        n_d.cnt = q_q.cnt + 4'd1;
                    end else if (fall && q_q.cnt == 4'd8) begin
                        n_d.st   = ST_WR_ACK;
                        n_d.oe   = 1'b1;
                        n_d.widx = q_q.idx;
                        if (q_q.idx < LAST_IDX) begin
                            n_d.we  = 1'b1;
                            n_d.idx = q_q.idx + 1'b1;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (fall) begin
                        n_d.st  = ST_WR;
                        n_d.oe  = 1'b0;
                        n_d.cnt = '0;
                    end
                end
                ST_RD: begin
                    if (fall) begin
                        if (q_q.cnt == 4'd7) begin
                            n_d.st = ST_RD_ACK;
                            n_d.oe = 1'b0;
                        end else begin
                            n_d.cnt = q_q.cnt + 4'd1;
                            n_d.sr  = {q_q.sr[6:0], 1'b0};
                            n_d.oe  = ~q_q.sr[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (rise) begin
                        n_d.ack = ~sda_s;
                    end else if (fall) begin
                        if (q_q.ack) begin
                            n_d.st  = ST_RD;
                            n_d.cnt = '0;
                            n_d.sr  = status;
                            n_d.oe  = ~status[7];
                        end else begin
                            n_d.st = ST_IDLE;
                            n_d.oe = 1'b0;
                        end
                    end
                end
                default: n_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.st    <= ST_IDLE;
            q_q.scl_p <= 1'b1;
            q_q.sda_p <= 1'b1;
        end else begin
            q_q <= n_d;
        end
    end

    assign sda_oe  = q_q.oe;
    assign wr_en   = q_q.we;
    assign wr_idx  = q_q.widx;
    assign wr_data = q_q.sr;

    AST_DRIVE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_q.oe) |-> !$past(scl_s)); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_IDLE) |-> !q_q.oe); // R5
    AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_RD_ACK && fall && !q_q.ack && !start_c && !stop_c)
        |=> (q_q.st == ST_IDLE && !q_q.oe)); // R5
    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.we |-> (q_q.widx < LAST_IDX)); // R3
    AST_ADDR_ACK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.st == ST_ADDR_ACK) |-> q_q.oe); // R1
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
    parameter int NREG  = 4,
    parameter int IDX_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_data,
    input  logic              sleep_i,
    input  logic              lock_i,
    output logic [NREG*8-1:0] regs_o,
    output logic              pwrdn_o,
    output logic [1:0]        port_pull_o,
    output logic              lock_o
);
    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic                 lock;
    } rf_t;

    rf_t rf_q, rf_d;

    always_comb begin
        rf_d      = rf_q;
        rf_d.lock = lock_i;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) rf_d.regs[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign regs_o      = rf_q.regs;
    assign pwrdn_o     = sleep_i | rf_q.regs[0][0];
    assign port_pull_o = rf_q.regs[0][2:1];
    assign lock_o      = rf_q.lock;

    AST_PORT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> (port_pull_o == $past(wr_data[2:1]))); // R8
    AST_SLEEP_FORCES_PD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> pwrdn_o); // R7
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
    parameter int NREG  = 4,
    parameter int IDX_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    input  logic              sleep_i,
    input  logic              lock_i,
    input  logic [6:0]        status_aux_i,
    output logic [NREG*8-1:0] ctrl_regs_o,
    output logic              pwrdn_o,
    output logic [1:0]        port_pull_o,
    output logic              lock_o
);
    logic [1:0]       line_s;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    i2c_in_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
    );

    i2c_bus_engine #(.NREG(NREG), .IDX_W(IDX_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
        .addr_sel(addr_sel_i), .status({lock_o, status_aux_i}),
        .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    ctrl_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .sleep_i(sleep_i), .lock_i(lock_i),
        .regs_o(ctrl_regs_o), .pwrdn_o(pwrdn_o), .port_pull_o(port_pull_o),
        .lock_o(lock_o)
    );
endmodule

// File: tb/sim_i2c_ctrl_slave.sv
`timescale 1ns/1ps
module sim_i2c_ctrl_slave;
    localparam int NREG = 4;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic sleep = 1'b0, lock = 1'b0;
    logic [6:0] aux = 7'd0;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic pwrdn, lock_o;
    logic [1:0] pull;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0;
    logic [7:0] m_regs [NREG];
    bit done = 0;

    always #5 clk = ~clk;

    i2c_ctrl_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .sleep_i(sleep),
        .lock_i(lock), .status_aux_i(aux), .ctrl_regs_o(regs),
        .pwrdn_o(pwrdn), .port_pull_o(pull), .lock_o(lock_o)
    );

    function automatic logic [7:0] exp_status(logic l, logic [6:0] a);
        return {l, a};
    endfunction
    function automatic logic exp_pwrdn(logic s, logic [7:0] r0);
        return s | r0[0];
    endfunction
    function automatic logic [1:0] exp_pull(logic [7:0] r0);
        return r0[2:1];
    endfunction
    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = m_regs[i];
        return f;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic bus_start();
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask
    task automatic bus_stop();
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
    endtask
    task automatic bit_out(logic b);
        sda_m = b; tick(Q); scl_m = 1; tick(Q); scl_m = 0; tick(Q);
    endtask
    task automatic bit_in(output logic r);
        sda_m = 1; tick(Q); scl_m = 1; tick(Q/2); r = sda_line; tick(Q/2); scl_m = 0; tick(Q);
    endtask
    task automatic byte_out(logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(r);
        acked = ~r;
    endtask
    // reads one byte; applies next_aux before the ack slot, chg_val after bit chg_at
    task automatic byte_in(logic ack_m, logic [6:0] next_aux, int chg_at,
                           logic [6:0] chg_val, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_in(r);
            b[i] = r;
            if (7 - i == chg_at) aux = chg_val;
        end
        aux = next_aux;
        bit_out(~ack_m);
    endtask
    task automatic write_txn(logic [6:0] adr, int n, logic [7:0] d [8], logic exp_ack);
        logic a;
        bus_start();
        byte_out({adr, 1'b0}, a);
        chk(a == exp_ack, "R1 address ack", a, exp_ack);
        for (int i = 0; i < n; i++) begin
            byte_out(d[i], a);
            chk(a == exp_ack, exp_ack ? "R2/R3 data ack" : "R1 ignored after mismatch", a, exp_ack);
            if (exp_ack && i < NREG) m_regs[i] = d[i];
        end
        bus_stop();
        tick(2);
        chk(regs == model_flat(), "R2/R3 register file", regs, model_flat());
    endtask

    initial begin
        logic [7:0] d [8];
        logic [7:0] b;
        logic a;
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < NREG; i++) m_regs[i] = 8'h00;
        tick(4);
        chk(sda_oe == 1'b0, "R11 reset sda", sda_oe, 0);
        chk(regs == '0, "R11 reset regs", regs, 0);
        chk(pull == 2'b00, "R8 reset ports", pull, 0);
        rst_n = 1'b1;
        tick(4);

        // R1: each select value, matching address
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            d[0] = 8'($urandom);
            write_txn(7'h60 + 7'(s), 1, d, 1'b1);
        end
        // R1: mismatch, bytes ignored
        addr_sel = 2'd2;
        d[0] = 8'hA5; d[1] = 8'h5A;
        write_txn(7'h61, 2, d, 1'b0);

        // R2/R3: overflow beyond last register
        addr_sel = 2'd0;
        for (int i = 0; i < 8; i++) d[i] = 8'(8'h10 + i);
        write_txn(7'h60, NREG + 2, d, 1'b1);

        // R7/R8: control bits of register 0
        d[0] = 8'b0000_0110;
        write_txn(7'h60, 1, d, 1'b1);
        chk(pull == exp_pull(d[0]), "R8 ports on", pull, exp_pull(d[0]));
        chk(pwrdn == exp_pwrdn(sleep, d[0]), "R7 pd off", pwrdn, 0);
        sleep = 1; tick(1);
        chk(pwrdn == 1'b1, "R7 sleep pin", pwrdn, 1);
        sleep = 0;
        d[0] = 8'b0000_0001;
        write_txn(7'h60, 1, d, 1'b1);
        chk(pwrdn == 1'b1, "R7 pd bit", pwrdn, 1);
        chk(pull == 2'b00, "R8 ports off", pull, 0);
        d[0] = 8'h00;
        write_txn(7'h60, 1, d, 1'b1);
        chk(pwrdn == 1'b0, "R7 both clear", pwrdn, 0);

        // R9: lock output
        lock = 1; tick(2);
        chk(lock_o == 1'b1, "R9 lock out", lock_o, 1);

        // R4/R5/R6: read sequence
        aux = 7'h2B;
        bus_start();
        byte_out({7'h60, 1'b1}, a);
        chk(a, "R1 read address ack", a, 1);
        byte_in(1'b1, 7'h11, -1, 7'h0, b);
        chk(b == exp_status(1'b1, 7'h2B), "R4 status byte 0", b, exp_status(1'b1, 7'h2B));
        byte_in(1'b1, 7'h3C, 3, 7'h7F, b);
        chk(b == exp_status(1'b1, 7'h11), "R6 status latched", b, exp_status(1'b1, 7'h11));
        byte_in(1'b0, 7'h3C, -1, 7'h0, b);
        chk(b == exp_status(1'b1, 7'h3C), "R4 status byte 2", b, exp_status(1'b1, 7'h3C));
        byte_in(1'b0, 7'h3C, -1, 7'h0, b);
        chk(b == 8'hFF, "R5 silent after nack", b, 8'hFF);
        chk(sda_oe == 1'b0, "R5 released", sda_oe, 0);
        bus_stop();

        // R10: restart in the middle of a byte discards it
        bus_start();
        byte_out({7'h60, 1'b0}, a);
        bit_out(1); bit_out(0); bit_out(1); bit_out(1);
        d[0] = 8'h04;
        write_txn(7'h60, 1, d, 1'b1);
        chk(regs[7:0] == 8'h04, "R10 restart index 0", regs[7:0], 8'h04);

        // random mix
        for (int it = 0; it < 30; it++) begin
            int s, n;
            logic [6:0] adr;
            s = int'($urandom_range(3));
            addr_sel = 2'(s);
            adr = ($urandom_range(9) == 0) ? 7'h60 + 7'((s + 1) % 4) : 7'h60 + 7'(s);
            if ($urandom_range(1) == 0) begin
                n = int'($urandom_range(1, NREG + 2));
                for (int i = 0; i < 8; i++) d[i] = 8'($urandom) & 8'hF9;
                write_txn(adr, n, d, adr == 7'h60 + 7'(s));
            end else begin
                logic [6:0] cur, nxt;
                lock = 1'($urandom); cur = 7'($urandom); aux = cur;
                tick(2);
                chk(lock_o == lock, "R9 lock follows", lock_o, lock);
                bus_start();
                byte_out({adr, 1'b1}, a);
                chk(a == (adr == 7'h60 + 7'(s)), "R1 read addr", a, adr == 7'h60 + 7'(s));
                n = int'($urandom_range(1, 3));
                for (int i = 0; i < n; i++) begin
                    nxt = 7'($urandom);
                    byte_in(i < n - 1, nxt, -1, 7'h0, b);
                    if (a) chk(b == exp_status(lock, cur), "R4 random status", b, exp_status(lock, cur));
                    else chk(b == 8'hFF, "R1 no reply", b, 8'hFF);
                    cur = nxt;
                end
                bus_stop();
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule